// File: doc/BRIEF.md
# Rectangle-to-Subtile Transfer Sequencer

This block splits a rectangular pixel copy into pieces. Each piece lies wholly inside one 1 KB subtile of a tiled surface. A request carries the box origin and size in pixels, a bytes-per-pixel code, the byte pitch of the linear buffer and the width of the tiled surface counted in microtiles. The microtile is a 64-byte block. The block walks the box in row-major order. For each piece it emits one command with these fields:

- the byte address of the subtile inside the tiled surface;
- the piece's x and y offset and its width and height inside that subtile;
- the byte offset of the piece's first pixel in the linear buffer, relative to the box origin;
- the row pitch to use inside the subtile;
- the load/store flag of the request, unchanged.

A separate copy engine consumes these commands and moves the data. The block itself moves no data.

Requests come in on a valid/ready port. It is ready only while the sequencer is idle. Commands leave on a valid/ready stream. While `pc_valid` is high and `pc_ready` is low, the command does not change and the walk does not advance. The consumer may stall for any number of cycles. A one-cycle `done` pulse follows the last command.

Top module: `subtile_xfer_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle. A request is taken only on a cycle where `req_valid` and `req_ready` are both high. While a box is being walked, `req_valid` and the request fields have no effect on the commands.
- R2: `req_cpp` encodes bytes per pixel as 0→1, 1→2, 2→4, 3→8. The subtile measures 32x32, 32x16, 16x16 or 8x16 pixels (width x height) for codes 0 to 3. The microtile is one quarter of the subtile in each dimension. `pc_stride` equals subtile width times bytes per pixel.
- R3: With sw the subtile width and x_end = x + w: `pc_xoff` = x mod sw, and `pc_w` = min(x_end − x, sw − `pc_xoff`).
- R4: With sh the subtile height and y_end = y + h: `pc_yoff` = y mod sh, and `pc_h` = min(y_end − y, sh − `pc_yoff`).
- R5: Pieces come out in row-major order. After each piece, x moves to the next multiple of sw above it. When that reaches x_end, x returns to the box origin and y moves to the next multiple of sh above it. The walk ends when y reaches y_end.
- R6: `pc_lin` is row base + column offset. Both start at 0. The column offset grows by piece width × bytes per pixel after each piece and is cleared when a row ends. At the end of each row, the row base grows by `req_lin_stride` × that row's piece height.
- R7: Take ux = 4·floor(x/sw) and uy = 4·floor(y/sh) as the microtile coordinates, and ts = `req_ut_stride`/8 (the stride must be a multiple of 8). Then tx = ux/8 and ty = uy/8. When ty is odd, tx is replaced by ts − tx − 1. The slot index is 2·((uy/4) mod 2) + ((ux/4) mod 2). The slot maps through {0,3,1,2} on even ty and {2,1,3,0} on odd ty. `pc_base` = 4096·(ty·ts + tx) + 1024·slot.
- R8: While `pc_valid` is high and `pc_ready` is low, every command field holds its value and `pc_valid` stays high. One command is consumed per cycle in which both are high.
- R9: `done` is high for exactly one cycle, in the cycle after the last command is consumed. A box of zero width or zero height produces no command, and its `done` comes in the cycle after the request is accepted. `req_ready` is high in the cycle after `done`.
- R10: `pc_store` carries the `req_store` value of the accepted request on every command of that box.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_x | input | XY_W | Box left edge, pixels |
| req_y | input | XY_W | Box top edge, pixels |
| req_w | input | XY_W | Box width, pixels |
| req_h | input | XY_W | Box height, pixels |
| req_cpp | input | 2 | Bytes-per-pixel code |
| req_lin_stride | input | LIN_W | Linear buffer row pitch, bytes |
| req_ut_stride | input | XY_W | Tiled surface width, microtiles |
| req_store | input | 1 | Direction flag, passed through |
| pc_valid | output | 1 | Command present |
| pc_ready | input | 1 | Consumer accepts command |
| pc_base | output | ADDR_W | Subtile byte address in tiled surface |
| pc_xoff | output | 6 | Piece x offset inside subtile |
| pc_yoff | output | 6 | Piece y offset inside subtile |
| pc_w | output | 6 | Piece width, pixels |
| pc_h | output | 6 | Piece height, pixels |
| pc_lin | output | LIN_W | Linear byte offset of piece |
| pc_stride | output | 7 | Row pitch inside subtile, bytes |
| pc_store | output | 1 | Direction flag of the request |
| done | output | 1 | One-cycle end-of-box pulse |

## Verification
The assertions assume the requester keeps requests legal:
- the tiled width is a multiple of 8 microtiles;
- the box lies inside the tiled surface;
- x + w and y + h do not wrap the coordinate width.

Under those terms, every piece fits its subtile and the address generator never sees a mirrored tile index below zero. The directed cases pick boxes inside small surfaces of 8 or 16 microtiles width. They cover all four pixel sizes and boxes that cross odd tile rows. Consumer stall patterns are applied, and junk requests are offered while a walk is in progress.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int PC_W  = 6;
  localparam int LTS_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  // log2 of subtile width in pixels for a bytes-per-pixel code
  function automatic logic [2:0] sub_w_log2(input logic [1:0] cpp_code);
    case (cpp_code)
      2'd0:    return 3'd5;
      2'd1:    return 3'd5;
      2'd2:    return 3'd4;
      default: return 3'd3;
    endcase
  endfunction

  // log2 of subtile height in pixels for a bytes-per-pixel code
  function automatic logic [2:0] sub_h_log2(input logic [1:0] cpp_code);
    case (cpp_code)
      2'd0:    return 3'd5;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/tsq_axis.sv
// One axis of piece geometry: offset, length, next aligned step, microtile base.
module tsq_axis #(
  parameter int CW = 13
) (
  input  logic [2:0]               sub_log2,
  input  logic [CW-1:0]            cur,
  input  logic [CW-1:0]            lim,
  output logic [tsq_pkg::PC_W-1:0] off,
  output logic [tsq_pkg::PC_W-1:0] len,
  output logic [CW-1:0]            nxt,
  output logic [CW-1:0]            ut4
);
  import tsq_pkg::*;

  logic [PC_W-1:0] span;
  logic [PC_W-1:0] mask;
  logic [PC_W-1:0] room;
  logic [CW-1:0]   left;

  always_comb begin
    span = PC_W'(1) << sub_log2;
    mask = span - PC_W'(1);
    off  = cur[PC_W-1:0] & mask;
    room = span - off;
    left = lim - cur;
    len  = (left < CW'(room)) ? left[PC_W-1:0] : room;
    nxt  = (cur | CW'(mask)) + CW'(1);
    ut4  = (cur >> sub_log2) << 2;
  end
endmodule

// File: rtl/tsq_addr.sv
// Subtile base address within a serpentine arrangement of 4 KB tiles.
module tsq_addr #(
  parameter int CW = 13,
  parameter int AW = 22
) (
  input  logic [CW-1:0] ut_x4,
  input  logic [CW-1:0] ut_y4,
  input  logic [CW-1:0] ut_stride,
  output logic [AW-1:0] base
);
  logic [CW-1:0] tile_stride;
  logic [CW-1:0] tile_x;
  logic [CW-1:0] tile_y;
  logic [CW-1:0] tile_x_dir;
  logic          odd_row;
  logic [1:0]    quad;
  logic [1:0]    slot;
  logic [AW-1:0] tile_num;

  always_comb begin
    tile_stride = ut_stride >> 3;
    tile_x      = ut_x4 >> 3;
    tile_y      = ut_y4 >> 3;
    odd_row     = tile_y[0];
    tile_x_dir  = odd_row ? (tile_stride - tile_x - CW'(1)) : tile_x;
    quad        = {ut_y4[2], ut_x4[2]};
    case ({odd_row, quad})
      3'b000:  slot = 2'd0;
      3'b001:  slot = 2'd3;
      3'b010:  slot = 2'd1;
      3'b011:  slot = 2'd2;
      3'b100:  slot = 2'd2;
      3'b101:  slot = 2'd1;
      3'b110:  slot = 2'd3;
      default: slot = 2'd0;
    endcase
    tile_num = AW'(tile_y) * AW'(tile_stride) + AW'(tile_x_dir);
    base     = (tile_num << 12) + (AW'(slot) << 10);
  end
endmodule

// File: rtl/tsq_walk.sv
// Walk state: request capture, current position and linear offset tracking.
module tsq_walk #(
  parameter int CW = 13,
  parameter int LW = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     fire,
  input  logic [CW-2:0]            req_x,
  input  logic [CW-2:0]            req_y,
  input  logic [CW-2:0]            req_w,
  input  logic [CW-2:0]            req_h,
  input  logic [1:0]               req_cpp,
  input  logic [LW-1:0]            req_lin_stride,
  input  logic [CW-2:0]            req_ut_stride,
  input  logic                     req_store,
  input  logic [CW-1:0]            nxt_x,
  input  logic [CW-1:0]            nxt_y,
  input  logic [tsq_pkg::PC_W-1:0] len_x,
  input  logic [tsq_pkg::PC_W-1:0] len_y,
  output tsq_pkg::seq_state_e      state,
  output logic [CW-1:0]            cur_x,
  output logic [CW-1:0]            cur_y,
  output logic [CW-1:0]            end_x,
  output logic [CW-1:0]            end_y,
  output logic [1:0]               cpp_q,
  output logic [CW-1:0]            ut_stride_q,
  output logic                     store_q,
  output logic [LW-1:0]            lin_off
);
  import tsq_pkg::*;

  logic [CW-1:0] x_start;
  logic [LW-1:0] lin_stride_q;
  logic [LW-1:0] row_base;
  logic [LW-1:0] col_off;
  logic          row_end;
  logic          box_empty;

  assign row_end   = (nxt_x >= end_x);
  assign box_empty = (req_w == '0) || (req_h == '0);
  assign lin_off   = row_base + col_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cur_x        <= '0;
      cur_y        <= '0;
      end_x        <= '0;
      end_y        <= '0;
      x_start      <= '0;
      cpp_q        <= '0;
      ut_stride_q  <= '0;
      store_q      <= 1'b0;
      lin_stride_q <= '0;
      row_base     <= '0;
      col_off      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cur_x        <= CW'(req_x);
            cur_y        <= CW'(req_y);
            x_start      <= CW'(req_x);
            end_x        <= CW'(req_x) + CW'(req_w);
            end_y        <= CW'(req_y) + CW'(req_h);
            cpp_q        <= req_cpp;
            ut_stride_q  <= CW'(req_ut_stride);
            store_q      <= req_store;
            lin_stride_q <= req_lin_stride;
            row_base     <= '0;
            col_off      <= '0;
            state        <= box_empty ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (fire) begin
            if (row_end) begin
              cur_x    <= x_start;
              cur_y    <= nxt_y;
              col_off  <= '0;
              row_base <= row_base + lin_stride_q * LW'(len_y);
              if (nxt_y >= end_y) state <= ST_DONE;
            end else begin
              cur_x   <= nxt_x;
              col_off <= col_off + (LW'(len_x) << cpp_q);
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: within a row the linear offset never moves backwards
  assert_col_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && fire && !row_end) |=> (lin_off > $past(lin_off)));
endmodule

// File: rtl/subtile_xfer_seq.sv
module subtile_xfer_seq #(
  parameter int XY_W   = 12,
  parameter int LIN_W  = 20,
  parameter int ADDR_W = 22
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [XY_W-1:0]           req_x,
  input  logic [XY_W-1:0]           req_y,
  input  logic [XY_W-1:0]           req_w,
  input  logic [XY_W-1:0]           req_h,
  input  logic [1:0]                req_cpp,
  input  logic [LIN_W-1:0]          req_lin_stride,
  input  logic [XY_W-1:0]           req_ut_stride,
  input  logic                      req_store,
  output logic                      pc_valid,
  input  logic                      pc_ready,
  output logic [ADDR_W-1:0]         pc_base,
  output logic [tsq_pkg::PC_W-1:0]  pc_xoff,
  output logic [tsq_pkg::PC_W-1:0]  pc_yoff,
  output logic [tsq_pkg::PC_W-1:0]  pc_w,
  output logic [tsq_pkg::PC_W-1:0]  pc_h,
  output logic [LIN_W-1:0]          pc_lin,
  output logic [tsq_pkg::LTS_W-1:0] pc_stride,
  output logic                      pc_store,
  output logic                      done
);
  import tsq_pkg::*;

  localparam int CW = XY_W + 1;
  localparam int FW = PC_W + 1;

  seq_state_e    state;
  logic          accept;
  logic          fire;
  logic [CW-1:0] cur_x, cur_y, end_x, end_y;
  logic [1:0]    cpp_q;
  logic [CW-1:0] ut_stride_q;
  logic [2:0]    sw_log2, sh_log2;

  logic [1:0][2:0]      ax_log2;
  logic [1:0][CW-1:0]   ax_cur, ax_lim, ax_nxt, ax_ut4;
  logic [1:0][PC_W-1:0] ax_off, ax_len;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign pc_valid  = (state == ST_RUN);
  assign fire      = pc_valid && pc_ready;
  assign done      = (state == ST_DONE);

  assign sw_log2 = sub_w_log2(cpp_q);
  assign sh_log2 = sub_h_log2(cpp_q);

  assign ax_log2 = {sh_log2, sw_log2};
  assign ax_cur  = {cur_y, cur_x};
  assign ax_lim  = {end_y, end_x};

  for (genvar a = 0; a < 2; a++) begin : g_axis
    tsq_axis #(.CW(CW)) u_axis (
      .sub_log2 (ax_log2[a]),
      .cur      (ax_cur[a]),
      .lim      (ax_lim[a]),
      .off      (ax_off[a]),
      .len      (ax_len[a]),
      .nxt      (ax_nxt[a]),
      .ut4      (ax_ut4[a])
    );
  end

  tsq_walk #(.CW(CW), .LW(LIN_W)) u_walk (
    .clk            (clk),
    .rst_n          (rst_n),
    .accept         (accept),
    .fire           (fire),
    .req_x          (req_x),
    .req_y          (req_y),
    .req_w          (req_w),
    .req_h          (req_h),
    .req_cpp        (req_cpp),
    .req_lin_stride (req_lin_stride),
    .req_ut_stride  (req_ut_stride),
    .req_store      (req_store),
    .nxt_x          (ax_nxt[0]),
    .nxt_y          (ax_nxt[1]),
    .len_x          (ax_len[0]),
    .len_y          (ax_len[1]),
    .state          (state),
    .cur_x          (cur_x),
    .cur_y          (cur_y),
    .end_x          (end_x),
    .end_y          (end_y),
    .cpp_q          (cpp_q),
    .ut_stride_q    (ut_stride_q),
    .store_q        (pc_store),
    .lin_off        (pc_lin)
  );

  tsq_addr #(.CW(CW), .AW(ADDR_W)) u_addr (
    .ut_x4     (ax_ut4[0]),
    .ut_y4     (ax_ut4[1]),
    .ut_stride (ut_stride_q),
    .base      (pc_base)
  );

  assign pc_xoff   = ax_off[0];
  assign pc_yoff   = ax_off[1];
  assign pc_w      = ax_len[0];
  assign pc_h      = ax_len[1];
  assign pc_stride = LTS_W'(1) << (sw_log2 + {1'b0, cpp_q});

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!pc_valid && !done));

  assert_fit_x_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> ((pc_w != '0) && ((FW'(pc_xoff) + FW'(pc_w)) <= (FW'(1) << sw_log2))));

  assert_fit_y_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> ((pc_h != '0) && ((FW'(pc_yoff) + FW'(pc_h)) <= (FW'(1) << sh_log2))));

  assert_base_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> (pc_base[9:0] == 10'd0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_valid && !pc_ready) |=> (pc_valid && $stable(pc_base) && $stable(pc_lin)
      && $stable(pc_xoff) && $stable(pc_yoff) && $stable(pc_w) && $stable(pc_h)
      && $stable(pc_store)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
endmodule

// File: tb/subtile_xfer_seq_bench.sv
module subtile_xfer_seq_bench;
  localparam int XY_W = 12;
  localparam int LIN_W = 20;
  localparam int ADDR_W = 22;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic req_ready;
  logic [XY_W-1:0] req_x, req_y, req_w, req_h, req_ut_stride;
  logic [1:0] req_cpp;
  logic [LIN_W-1:0] req_lin_stride;
  logic req_store;
  logic pc_valid, pc_ready;
  logic [ADDR_W-1:0] pc_base;
  logic [5:0] pc_xoff, pc_yoff, pc_w, pc_h;
  logic [LIN_W-1:0] pc_lin;
  logic [6:0] pc_stride;
  logic pc_store, done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  subtile_xfer_seq #(.XY_W(XY_W), .LIN_W(LIN_W), .ADDR_W(ADDR_W)) u_subtile_xfer_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h), .req_cpp(req_cpp),
    .req_lin_stride(req_lin_stride), .req_ut_stride(req_ut_stride), .req_store(req_store),
    .pc_valid(pc_valid), .pc_ready(pc_ready), .pc_base(pc_base), .pc_xoff(pc_xoff),
    .pc_yoff(pc_yoff), .pc_w(pc_w), .pc_h(pc_h), .pc_lin(pc_lin), .pc_stride(pc_stride),
    .pc_store(pc_store), .done(done)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int sw_of(input int c);
    int t[4] = '{32, 32, 16, 8};
    return t[c];
  endfunction

  function automatic int sh_of(input int c);
    int t[4] = '{32, 16, 16, 16};
    return t[c];
  endfunction

  function automatic int model_base(input int ux, input int uy, input int us);
    int ts, tx, ty, idx, slot;
    int even_m[4] = '{0, 3, 1, 2};
    int odd_m[4]  = '{2, 1, 3, 0};
    ts = us / 8; tx = ux / 8; ty = uy / 8;
    if (ty % 2 == 1) tx = ts - tx - 1;
    idx = ((uy / 4) % 2) * 2 + ((ux / 4) % 2);
    slot = (ty % 2 == 1) ? odd_m[idx] : even_m[idx];
    return 4096 * (ty * ts + tx) + 1024 * slot;
  endfunction

  task automatic run_case(input string tag, input int x, input int y, input int w, input int h,
                          input int cpp, input int lstr, input int ustr, input bit st,
                          input int rpat, input bit poke);
    int sw, sh, cx, cy, xe, ye, col, rowb, live, guard;
    int xo, yo, pw, ph, eb, el;
    bit stalled;
    logic [ADDR_W-1:0] s_base;
    logic [LIN_W-1:0] s_lin;
    logic [5:0] s_xo, s_yo, s_w, s_h;
    sw = sw_of(cpp); sh = sh_of(cpp);
    chk(req_ready === 1'b1, {tag, " R1 ready before request"}, req_ready, 1);
    req_x = XY_W'(x); req_y = XY_W'(y); req_w = XY_W'(w); req_h = XY_W'(h);
    req_cpp = 2'(cpp); req_lin_stride = LIN_W'(lstr); req_ut_stride = XY_W'(ustr);
    req_store = st; req_valid = 1'b1;
    @(negedge clk);
    if (poke) begin
      req_x = 12'd3; req_y = 12'd5; req_w = 12'd9; req_h = 12'd2;
      req_cpp = 2'd0; req_lin_stride = 20'd7; req_store = ~st;
    end else req_valid = 1'b0;
    cx = x; cy = y; xe = x + w; ye = y + h; col = 0; rowb = 0;
    live = (w > 0 && h > 0) ? 1 : 0;
    stalled = 1'b0; guard = 0;
    forever begin
      pc_ready = (rpat == 0) ? 1'b1 : ((guard % rpat) != 0);
      if (done) begin
        chk(live == 0, {tag, " R9 done before last piece"}, live, 0);
        chk(pc_valid == 1'b0, {tag, " R9 no command with done"}, pc_valid, 0);
        break;
      end
      if (live == 0) begin
        chk(1'b0, {tag, " R9 done missing after last piece"}, done, 1);
        break;
      end
      chk(pc_valid == 1'b1, {tag, " R8 valid while pieces remain"}, pc_valid, 1);
      chk(req_ready == 1'b0, {tag, " R1 busy"}, req_ready, 0);
      if (stalled) begin
        chk(pc_base == s_base && pc_lin == s_lin && pc_xoff == s_xo && pc_yoff == s_yo
            && pc_w == s_w && pc_h == s_h, {tag, " R8 hold under stall"}, pc_base, s_base);
      end
      if (pc_ready) begin
        xo = cx % sw; pw = (xe - cx < sw - xo) ? xe - cx : sw - xo;
        yo = cy % sh; ph = (ye - cy < sh - yo) ? ye - cy : sh - yo;
        eb = model_base((cx / sw) * 4, (cy / sh) * 4, ustr);
        el = rowb + col;
        chk(pc_xoff == xo, {tag, " R5 order x offset"}, pc_xoff, xo);
        chk(pc_yoff == yo, {tag, " R5 order y offset"}, pc_yoff, yo);
        chk(pc_w == pw, {tag, " R3 width"}, pc_w, pw);
        chk(pc_h == ph, {tag, " R4 height"}, pc_h, ph);
        chk(pc_base == eb, {tag, " R7 base"}, pc_base, eb);
        chk(pc_lin == el, {tag, " R6 linear"}, pc_lin, el);
        chk(pc_stride == sw * (1 << cpp), {tag, " R2 stride"}, pc_stride, sw * (1 << cpp));
        chk(pc_store == st, {tag, " R10 direction"}, pc_store, st);
        if ((cx / sw + 1) * sw >= xe) begin
          cx = x; col = 0; rowb = rowb + lstr * ph;
          cy = (cy / sh + 1) * sh;
          if (cy >= ye) live = 0;
        end else begin
          cx = (cx / sw + 1) * sw;
          col = col + pw * (1 << cpp);
        end
        stalled = 1'b0;
      end else begin
        stalled = 1'b1;
        s_base = pc_base; s_lin = pc_lin; s_xo = pc_xoff; s_yo = pc_yoff; s_w = pc_w; s_h = pc_h;
      end
      guard++;
      if (guard > 5000) begin
        chk(1'b0, {tag, " R5 walk did not finish"}, guard, 5000);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0; pc_ready = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, {tag, " R9 single pulse then idle R1"}, done, 0);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "reset R1 ready", req_ready, 1);
    chk(pc_valid == 1'b0, "reset R8 no command", pc_valid, 0);
    chk(done == 1'b0, "reset R9 no done", done, 0);
  endtask

  task automatic t_single_aligned;
    run_case("single", 0, 0, 16, 16, 2, 64, 16, 1'b0, 0, 1'b0);
  endtask

  task automatic t_partial_edges;
    run_case("partial", 5, 3, 40, 30, 2, 400, 16, 1'b1, 0, 1'b0);
  endtask

  task automatic t_odd_rows_stall;
    run_case("oddrow", 10, 50, 70, 30, 0, 128, 16, 1'b0, 3, 1'b0);
  endtask

  task automatic t_wide_pixel;
    run_case("cpp8", 3, 14, 12, 20, 3, 96, 16, 1'b1, 2, 1'b0);
  endtask

  task automatic t_half_pixel;
    run_case("cpp2full", 0, 0, 32, 16, 1, 64, 8, 1'b1, 0, 1'b0);
    run_case("cpp2dot", 31, 47, 1, 1, 1, 64, 8, 1'b0, 0, 1'b0);
  endtask

  task automatic t_zero_area;
    run_case("zerow", 4, 4, 0, 5, 2, 64, 16, 1'b0, 0, 1'b0);
    run_case("zeroh", 4, 4, 5, 0, 0, 64, 16, 1'b1, 0, 1'b0);
  endtask

  task automatic t_busy_ignored;
    run_case("busy", 7, 9, 30, 20, 2, 200, 16, 1'b1, 4, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog R9 run did not end", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; pc_ready = 1'b0;
    req_x = '0; req_y = '0; req_w = '0; req_h = '0; req_cpp = '0;
    req_lin_stride = '0; req_ut_stride = '0; req_store = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_aligned();
    t_partial_edges();
    t_odd_rows_stall();
    t_wide_pixel();
    t_half_pixel();
    t_zero_area();
    t_busy_ignored();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule